// File: doc/BRIEF.md
# SDRAM Command Timing Guard

This block sits beside a four-bank SDRAM controller and decides, cycle by cycle, whether the command the controller wants to send may go out without breaking the device's minimum spacing rules. The controller presents one request per cycle: an opcode (open a row, read, write, close a row, or stop a burst) and a bank number. In the same cycle the guard answers with `grant`. A command counts as sent only in a cycle where both `req_valid` and `grant` are high. The guard does not queue anything. When a request is refused, the controller either holds it or replaces it.

The row and bank delays are given as picosecond parameters together with the clock period. At elaboration the guard converts each of them to a clock count, rounding up. Write recovery is counted in clocks directly. A configuration input shortens the recovery for slow clocks with manually issued precharges. Each bank has its own set of down-counters, and one counter is shared across banks for the spacing between row opens. The guard also reports a protocol-error pulse for commands that do not fit the bank's state. It flags a row that has been held open past its maximum lifetime. After a read is cut short, it reports how many read words the device will still deliver for the programmed CAS latency.

Top module: `sdram_cmd_guard`

## Requirements
- R1: After reset all banks are idle, and `grant`, `proto_err`, `keep_words` and `ras_over` are all low or zero. `grant` is never high without `req_valid`.
- R2: A read or write to a bank is granted no earlier than RCD clocks after that bank's row was opened. RCD is ceil(19 ns / period), which is 2 at the default 10 ns. All nanosecond limits are rounded up the same way.
- R3: An open (opcode 0) to a bank is granted no earlier than RP clocks (2) after a precharge closed that bank's row.
- R4: Two opens are granted at least RRD clocks (2) apart, whatever their banks.
- R5: A precharge (opcode 3) to an open bank is granted no earlier than RAS clocks (5) after the row was opened.
- R6: Two opens of the same bank are granted at least RC clocks (7) apart.
- R7: A precharge to an open bank waits at least 2 clocks after the last write (opcode 2) to that bank, or 1 clock if `slow_manual` was high when the write was sent.
- R8: A burst stop (opcode 4) is granted in every cycle it is requested. Reads (opcode 1) and writes to an open bank whose RCD wait has elapsed are granted on consecutive cycles, including directly after a write.
- R9: A read or write to an idle bank, or an open to a bank whose row is already open, is refused. `proto_err` is then high in the next cycle, and the bank state is unchanged.
- R10: `ras_over[b]` is high from the cycle RASMAX+1 clocks after bank b's row opened, for as long as the row stays open. RASMAX is 100 us, which is 10000 clocks at the default.
- R11: In the cycle after a granted precharge or burst stop that cuts short a read, `keep_words` is 2 for `cas_lat`=3, 1 for 2, and 0 for 1. Otherwise it is 0. A read stays pending until the next granted write, precharge or burst stop.
- R12: `bank_open[b]` rises in the cycle after a granted open of bank b and falls in the cycle after a granted precharge of it. A precharge to an idle bank is granted and changes nothing. Opcodes 5 to 7 are never granted and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A command is requested this cycle |
| req_op | input | 3 | Opcode: 0 open, 1 read, 2 write, 3 precharge, 4 burst stop |
| req_bank | input | 2 | Target bank |
| cas_lat | input | 2 | Programmed CAS latency (1 to 3) |
| slow_manual | input | 1 | Allow 1-clock write recovery (below 100 MHz, manual precharge) |
| grant | output | 1 | Request may issue this cycle (combinational) |
| bank_open | output | 4 | Per-bank row-open flag |
| proto_err | output | 1 | Previous cycle's request did not fit the bank state |
| ras_over | output | 4 | Per-bank row held open beyond its maximum lifetime |
| keep_words | output | 2 | Read words still delivered after the last interruption |

## Verification
`grant` is combinational, so it is compared in the same cycle as the request. The bench samples it shortly after the inputs change at the falling edge. `bank_open`, `proto_err` and `keep_words` each pass through one register, so they are compared one cycle after the command that caused them. `ras_over` is compared in every cycle against the age of the row in the reference model. Each timed command is requested again on every cycle from the earliest moment the controller could have sent it. The model then predicts the exact first cycle that should be granted, so both an early grant and a late grant are reported.

// File: rtl/sdram_guard_pkg.sv
`timescale 1ns/1ps
package sdram_guard_pkg;

    typedef enum logic [2:0] {
        OP_ACT = 3'd0,
        OP_RD  = 3'd1,
        OP_WR  = 3'd2,
        OP_PRE = 3'd3,
        OP_BST = 3'd4
    } guard_op_e;

    // Whole clocks covering a delay, rounded up.
    function automatic int unsigned ps_to_clk(input int unsigned t_ps, input int unsigned clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/sdram_guard_bank.sv
`timescale 1ns/1ps
module sdram_guard_bank #(
    parameter int unsigned RCD_CYC    = 2,
    parameter int unsigned RP_CYC     = 2,
    parameter int unsigned RAS_CYC    = 5,
    parameter int unsigned RC_CYC     = 7,
    parameter int unsigned RASMAX_CYC = 10000,
    parameter int unsigned CW         = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic do_act,
    input  logic do_wr,
    input  logic do_pre,
    input  logic slow_manual,
    output logic is_open,
    output logic act_ok,
    output logic col_ok,
    output logic pre_ok,
    output logic ras_over
);
    localparam int unsigned AW = $clog2(RASMAX_CYC + 1);
    localparam logic [CW-1:0] RCD_LD  = CW'((RCD_CYC > 0) ? RCD_CYC - 1 : 0);
    localparam logic [CW-1:0] RP_LD   = CW'((RP_CYC  > 0) ? RP_CYC  - 1 : 0);
    localparam logic [CW-1:0] RAS_LD  = CW'((RAS_CYC > 0) ? RAS_CYC - 1 : 0);
    localparam logic [CW-1:0] RC_LD   = CW'((RC_CYC  > 0) ? RC_CYC  - 1 : 0);
    localparam logic [AW-1:0] AGE_LIM = AW'(RASMAX_CYC);

    typedef struct packed {
        logic          open;
        logic [CW-1:0] rcd;
        logic [CW-1:0] ras;
        logic [CW-1:0] rc;
        logic [CW-1:0] rp;
        logic [CW-1:0] wrr;
        logic [AW-1:0] age;
    } bank_st_t;

    bank_st_t st_d, st_q;

    function automatic logic [CW-1:0] dn(input logic [CW-1:0] v);
        return (v == '0) ? v : v - CW'(1);
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.rcd = dn(st_q.rcd);
        st_d.ras = dn(st_q.ras);
        st_d.rc  = dn(st_q.rc);
        st_d.rp  = dn(st_q.rp);
        st_d.wrr = dn(st_q.wrr);
        if (st_q.open && st_q.age != AGE_LIM)
            st_d.age = st_q.age + AW'(1);
        if (do_act) begin
            st_d.open = 1'b1;
            st_d.rcd  = RCD_LD;
            st_d.ras  = RAS_LD;
            st_d.rc   = RC_LD;
            st_d.age  = '0;
        end
        if (do_wr)
            st_d.wrr = slow_manual ? CW'(0) : CW'(1);
        if (do_pre && st_q.open) begin
            st_d.open = 1'b0;
            st_d.rp   = RP_LD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign is_open  = st_q.open;
    assign act_ok   = !st_q.open && (st_q.rp == '0) && (st_q.rc == '0);
    assign col_ok   = st_q.open && (st_q.rcd == '0);
    assign pre_ok   = !st_q.open || ((st_q.ras == '0) && (st_q.wrr == '0));
    assign ras_over = st_q.open && (st_q.age == AGE_LIM);
endmodule

// File: rtl/sdram_guard_shared.sv
`timescale 1ns/1ps
module sdram_guard_shared #(
    parameter int unsigned RRD_CYC = 2,
    parameter int unsigned CW      = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       do_act,
    input  logic       do_rd,
    input  logic       do_wr,
    input  logic       do_pre,
    input  logic       do_bst,
    input  logic [1:0] cas_lat,
    output logic       rrd_ok,
    output logic [1:0] keep_words
);
    localparam logic [CW-1:0] RRD_LD = CW'((RRD_CYC > 0) ? RRD_CYC - 1 : 0);

    typedef struct packed {
        logic [CW-1:0] rrd;
        logic          rd_pend;
        logic [1:0]    kw;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic [1:0] tail_words;

    always_comb begin
        unique case (cas_lat)
            2'd3:    tail_words = 2'd2;
            2'd2:    tail_words = 2'd1;
            default: tail_words = 2'd0;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.kw  = 2'd0;
        if (st_q.rrd != '0) st_d.rrd = st_q.rrd - CW'(1);
        if (do_act) st_d.rrd = RRD_LD;
        if (do_rd)  st_d.rd_pend = 1'b1;
        if ((do_pre || do_bst) && st_q.rd_pend) st_d.kw = tail_words;
        if (do_wr || do_pre || do_bst) st_d.rd_pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rrd_ok     = (st_q.rrd == '0);
    assign keep_words = st_q.kw;
endmodule

// File: rtl/sdram_cmd_guard.sv
`timescale 1ns/1ps
module sdram_cmd_guard
    import sdram_guard_pkg::*;
#(
    parameter int unsigned BANKS       = 4,
    parameter int unsigned CLK_PS      = 10000,
    parameter int unsigned T_RCD_PS    = 19000,
    parameter int unsigned T_RP_PS     = 19000,
    parameter int unsigned T_RRD_PS    = 15000,
    parameter int unsigned T_RAS_PS    = 45000,
    parameter int unsigned T_RC_PS     = 65000,
    parameter int unsigned T_RASMAX_PS = 100000000
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req_valid,
    input  logic [2:0]                            req_op,
    input  logic [(BANKS > 1 ? $clog2(BANKS) : 1)-1:0] req_bank,
    input  logic [1:0]                            cas_lat,
    input  logic                                  slow_manual,
    output logic                                  grant,
    output logic [BANKS-1:0]                      bank_open,
    output logic                                  proto_err,
    output logic [BANKS-1:0]                      ras_over,
    output logic [1:0]                            keep_words
);
    localparam int unsigned BW         = (BANKS > 1) ? $clog2(BANKS) : 1;
    localparam int unsigned RCD_CYC    = ps_to_clk(T_RCD_PS, CLK_PS);
    localparam int unsigned RP_CYC     = ps_to_clk(T_RP_PS, CLK_PS);
    localparam int unsigned RRD_CYC    = ps_to_clk(T_RRD_PS, CLK_PS);
    localparam int unsigned RAS_CYC    = ps_to_clk(T_RAS_PS, CLK_PS);
    localparam int unsigned RC_CYC     = ps_to_clk(T_RC_PS, CLK_PS);
    localparam int unsigned RASMAX_CYC = ps_to_clk(T_RASMAX_PS, CLK_PS);
    localparam int unsigned M1 = (RCD_CYC > RP_CYC) ? RCD_CYC : RP_CYC;
    localparam int unsigned M2 = (RRD_CYC > RAS_CYC) ? RRD_CYC : RAS_CYC;
    localparam int unsigned M3 = (M1 > M2) ? M1 : M2;
    localparam int unsigned SHORT_MAX = (M3 > RC_CYC) ? M3 : ((RC_CYC > 2) ? RC_CYC : 2);
    localparam int unsigned CW = $clog2(SHORT_MAX + 1);

    typedef struct packed {
        logic perr;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [BANKS-1:0] act_ok, col_ok, pre_ok;
    logic             rrd_ok, legal, fits;
    logic             do_act, do_rd, do_wr, do_pre, do_bst;
    guard_op_e        op;

    assign op = guard_op_e'(req_op);

    always_comb begin
        legal = 1'b0;
        fits  = 1'b1;
        case (op)
            OP_ACT: begin
                legal = act_ok[req_bank] && rrd_ok;
                fits  = !bank_open[req_bank];
            end
            OP_RD, OP_WR: begin
                legal = col_ok[req_bank];
                fits  = bank_open[req_bank];
            end
            OP_PRE:  legal = pre_ok[req_bank];
            OP_BST:  legal = 1'b1;
            default: legal = 1'b0;
        endcase
    end

    assign grant  = req_valid && legal;
    assign do_act = grant && (op == OP_ACT);
    assign do_rd  = grant && (op == OP_RD);
    assign do_wr  = grant && (op == OP_WR);
    assign do_pre = grant && (op == OP_PRE);
    assign do_bst = grant && (op == OP_BST);

    for (genvar i = 0; i < BANKS; i++) begin : g_bank
        logic sel;
        assign sel = (req_bank == BW'(i));
        sdram_guard_bank #(
            .RCD_CYC(RCD_CYC), .RP_CYC(RP_CYC), .RAS_CYC(RAS_CYC),
            .RC_CYC(RC_CYC), .RASMAX_CYC(RASMAX_CYC), .CW(CW)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .do_act     (do_act && sel),
            .do_wr      (do_wr && sel),
            .do_pre     (do_pre && sel),
            .slow_manual(slow_manual),
            .is_open    (bank_open[i]),
            .act_ok     (act_ok[i]),
            .col_ok     (col_ok[i]),
            .pre_ok     (pre_ok[i]),
            .ras_over   (ras_over[i])
        );
    end

    sdram_guard_shared #(.RRD_CYC(RRD_CYC), .CW(CW)) u_shared (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_act    (do_act),
        .do_rd     (do_rd),
        .do_wr     (do_wr),
        .do_pre    (do_pre),
        .do_bst    (do_bst),
        .cas_lat   (cas_lat),
        .rrd_ok    (rrd_ok),
        .keep_words(keep_words)
    );

    always_comb begin
        st_d.perr = req_valid && !fits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign proto_err = st_q.perr;
endmodule

// File: rtl/sdram_guard_chk.sv
`timescale 1ns/1ps
module sdram_guard_chk #(
    parameter int unsigned BANKS   = 4,
    parameter int unsigned RRD_CYC = 2
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  req_valid,
    input logic [2:0]                            req_op,
    input logic [(BANKS > 1 ? $clog2(BANKS) : 1)-1:0] req_bank,
    input logic                                  grant,
    input logic [BANKS-1:0]                      bank_open,
    input logic                                  proto_err,
    input logic [1:0]                            keep_words
);
    // R1: no grant without a request
    a_r1_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> req_valid);

    // R8: burst stop never waits
    a_r8_bst_always: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd4) |-> grant);

    // R9: column command to an idle bank refused and flagged next cycle
    a_r9_idle_col_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == 3'd1 || req_op == 3'd2) && !bank_open[req_bank]) |-> !grant);

    a_r9_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd0 && bank_open[req_bank]) |=> proto_err);

    // R12: bank state follows granted open and precharge
    a_r12_open_after_act: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && grant && req_op == 3'd0) |=> bank_open[$past(req_bank)]);

    a_r12_closed_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && grant && req_op == 3'd3) |=> !bank_open[$past(req_bank)]);

    // R11: surviving word count only after an interrupting command
    a_r11_kw_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_words != 2'd0) |-> $past(grant && (req_op == 3'd3 || req_op == 3'd4)));

    a_r11_kw_max: assert property (@(posedge clk) disable iff (!rst_n)
        keep_words <= 2'd2);

    // R4: opens never granted on adjacent cycles when spacing is two or more
    if (RRD_CYC >= 2) begin : g_rrd
        a_r4_act_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            (grant && req_op == 3'd0) |=> !(grant && req_op == 3'd0));
    end
endmodule

bind sdram_cmd_guard sdram_guard_chk #(.BANKS(BANKS), .RRD_CYC(RRD_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_bank  (req_bank),
    .grant     (grant),
    .bank_open (bank_open),
    .proto_err (proto_err),
    .keep_words(keep_words)
);

// File: tb/sdram_cmd_guard_test.sv
`timescale 1ns/1ps
module sdram_cmd_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_PS = CLK_PERIOD * 1000;
    localparam int RCD    = (19000 + CLK_PS - 1) / CLK_PS;
    localparam int RP     = (19000 + CLK_PS - 1) / CLK_PS;
    localparam int RRD    = (15000 + CLK_PS - 1) / CLK_PS;
    localparam int RAS    = (45000 + CLK_PS - 1) / CLK_PS;
    localparam int RC     = (65000 + CLK_PS - 1) / CLK_PS;
    localparam int RASMAX = (100000000 + CLK_PS - 1) / CLK_PS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = 3'd0;
    logic [1:0] req_bank = 2'd0;
    logic [1:0] cas_lat = 2'd3;
    logic       slow_manual = 1'b0;
    logic       grant;
    logic [3:0] bank_open;
    logic       proto_err;
    logic [3:0] ras_over;
    logic [1:0] keep_words;

    sdram_cmd_guard #(.CLK_PS(CLK_PS)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .cas_lat(cas_lat), .slow_manual(slow_manual),
        .grant(grant), .bank_open(bank_open), .proto_err(proto_err),
        .ras_over(ras_over), .keep_words(keep_words)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    int  last_act[4];
    int  last_pre[4];
    int  last_wr[4];
    int  wr_rdl[4];
    bit  mopen[4];
    int  last_act_any = -100000;
    bit  rpend = 0;
    int  exp_kw = 0;
    bit  exp_perr = 0;
    int  cyc = 0;
    bit  last_g = 0;

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at step %0d: actual %0d expected %0d", req, cyc, got, exp);
        end
    endtask

    task automatic step(input bit v, input int op, input int b);
        bit    eg;
        string tag;
        @(negedge clk);
        req_valid = v;
        req_op    = 3'(op);
        req_bank  = 2'(b);
        #1;
        eg = 0;
        tag = "R12";
        if (v) begin
            case (op)
                0: begin
                    tag = "R3/R4/R6/R9";
                    eg = !mopen[b] && cyc >= last_pre[b] + RP && cyc >= last_act[b] + RC
                         && cyc >= last_act_any + RRD;
                end
                1, 2: begin
                    tag = "R2/R8/R9";
                    eg = mopen[b] && cyc >= last_act[b] + RCD;
                end
                3: begin
                    tag = "R5/R7";
                    eg = !mopen[b] || (cyc >= last_act[b] + RAS && cyc >= last_wr[b] + wr_rdl[b]);
                end
                4: begin
                    tag = "R8";
                    eg = 1;
                end
                default: eg = 0;
            endcase
        end else begin
            tag = "R1";
        end
        chk(grant == eg, tag, int'(grant), int'(eg));
        for (int i = 0; i < 4; i++) begin
            chk(bank_open[i] == mopen[i], "R12 bank_open", int'(bank_open[i]), int'(mopen[i]));
            chk(ras_over[i] == (mopen[i] && (cyc - last_act[i] > RASMAX)), "R10 ras_over",
                int'(ras_over[i]), int'(mopen[i] && (cyc - last_act[i] > RASMAX)));
        end
        chk(proto_err == exp_perr, "R9 proto_err", int'(proto_err), int'(exp_perr));
        chk(int'(keep_words) == exp_kw, "R11 keep_words", int'(keep_words), exp_kw);
        last_g = eg;
        @(posedge clk);
        exp_perr = v && (((op == 1 || op == 2) && !mopen[b]) || (op == 0 && mopen[b]));
        exp_kw = 0;
        if (eg && (op == 3 || op == 4) && rpend)
            exp_kw = (cas_lat == 2'd3) ? 2 : (cas_lat == 2'd2) ? 1 : 0;
        if (eg) begin
            case (op)
                0: begin mopen[b] = 1; last_act[b] = cyc; last_act_any = cyc; end
                1: rpend = 1;
                2: begin last_wr[b] = cyc; wr_rdl[b] = slow_manual ? 1 : 2; rpend = 0; end
                3: begin
                    if (mopen[b]) begin mopen[b] = 0; last_pre[b] = cyc; end
                    rpend = 0;
                end
                4: rpend = 0;
                default: ;
            endcase
        end
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 0, 0);
    endtask

    // Request on every cycle until the model expects the grant.
    task automatic hold(input int op, input int b);
        for (int k = 0; k < 40; k++) begin
            step(1, op, b);
            if (last_g) break;
        end
        chk(last_g, "R2/R3/R5/R7 eventual grant", int'(last_g), 1);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            last_act[i] = -100000; last_pre[i] = -100000;
            last_wr[i] = -100000;  wr_rdl[i] = 2; mopen[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        idle(3);
        // R9: read to idle bank
        step(1, 1, 0);
        step(1, 2, 2);
        // R2/R4/R8: open, second open spaced, column commands
        step(1, 0, 0);
        hold(0, 1);
        hold(1, 0);
        step(1, 2, 0);
        step(1, 1, 0);
        step(1, 2, 0);
        // R5/R7: precharge after write
        hold(3, 0);
        // R3/R6: reopen
        hold(0, 0);
        // R9: open of an open bank
        step(1, 0, 0);
        // R12: invalid opcode, precharge to idle bank
        step(1, 5, 1);
        step(1, 3, 3);
        // R8: burst stop
        step(1, 4, 2);
        hold(2, 1);
        step(1, 4, 1);
        hold(3, 1);
        hold(3, 0);
        idle(2);

        // R7: one-clock recovery with slow_manual
        slow_manual = 1'b1;
        hold(0, 2);
        idle(6);
        step(1, 2, 2);
        hold(3, 2);
        slow_manual = 1'b0;
        hold(0, 3);
        idle(6);
        step(1, 2, 3);
        hold(3, 3);
        idle(2);

        // R11: interrupted reads for each CAS latency
        for (int cl = 1; cl <= 3; cl++) begin
            cas_lat = 2'(cl);
            hold(0, 1);
            hold(1, 1);
            step(1, 4, 0);
            step(0, 0, 0);
            step(1, 1, 1);
            hold(3, 1);
            idle(2);
        end

        // R10: row held open too long
        hold(0, 0);
        idle(RASMAX + 3);
        hold(3, 0);
        idle(2);

        summary();
        $finish;
    end
endmodule